// File: doc/BRIEF.md
# Indirect Interrupt Redirection Controller

This block routes a set of interrupt input pins to interrupt messages. Software reaches its small register file only through two windows: it writes a register number into the index window, then reads or writes the chosen 32-bit register through the data window. The register file has an identification register, a read-only version/capability register, an arbitration register, and one 64-bit redirection entry per pin. Each entry holds two words at consecutive indices.

Each pin is sampled as edge or level triggered, with its own polarity. When an unmasked pin becomes active, the block presents a message on a valid/ready output. The message carries the entry's vector, delivery mode, destination mode and destination. Once `msg_valid` rises, the message and all its fields stay unchanged until a cycle in which `msg_ready` is high. That cycle completes the handshake. A new message can appear no sooner than one cycle later. Pending pins are served lowest pin number first, one per handshake. Level-triggered entries wait for an end-of-interrupt pulse whose vector matches before they can fire again.

Top module: `irq_route_ctl`

## Requirements
- R1: A write with `bus_addr`=0x00 stores `bus_wdata[7:0]` as the index. Reading at 0x00 returns the index. A read or write with `bus_addr`=0x10 reaches the register that the index selects. Repeated data writes with no new index write keep updating the same register. The read data is combinational from the current index.
- R2: Register 0x00 has these fields:
  - bits 31:24 hold a writable unit ID, reset 0;
  - bit 15 and bit 14 are fixed flags set by parameters, 0 by default;
  - all other bits read zero.
- R3: Register 0x01 is read-only and has these fields:
  - bits 7:0 hold VERSION (default 0x20);
  - bit 15 holds a capability flag (default 1);
  - bits 23:16 hold NUM_PINS-1;
  - all other bits read zero.
  With the defaults it reads 0x00178020, and writes leave it unchanged.
- R4: Register 0x02 has a writable 4-bit arbitration ID in bits 27:24, reset 0. All other bits read zero.
- R5: Pin p's entry occupies two indices. Its low word is at index 0x10+2p and its high word at 0x11+2p.
  - Low-word fields: bits 7:0 vector, 10:8 delivery mode, 11 destination mode (1 = logical), 12 delivery status, 13 polarity (1 = active low), 14 remote IRR, 15 trigger (1 = level), 16 mask (1 = disabled).
  - High-word field: bits 31:24 destination.
  - Writable bits: low-word mask 0x0001AFFF and high-word mask 0xFF000000.
  - Reset values: low word 0x00010000, high word 0.
  - Indices that are not implemented read zero, and writes to them are ignored.
- R6: An edge-triggered, unmasked pin produces exactly one message for each inactive-to-active transition. It produces none while it stays active and none on the return to inactive.
- R7: Level-triggered entries:
  - An active, unmasked level entry produces a message.
  - Accepting that message sets remote IRR (bit 14), and the entry stays quiet.
  - An end-of-interrupt pulse with a matching vector clears remote IRR, and the entry fires again if the pin is still active.
  - An end-of-interrupt pulse with a different vector has no effect.
- R8: No message is produced when the entry is masked or its delivery mode is 3 or 6. The valid modes are 0, 1, 2, 4, 5 and 7.
- R9: Message fields:
  - `msg_vector` is the entry's vector and `msg_mode` its delivery mode.
  - `msg_logical` is the entry's destination mode.
  - `msg_dest` is all 8 destination bits in logical mode. In physical mode it is {4'b0, destination[3:0]}.
- R10: Delivery status (bit 12) reads 1 while the entry's request is pending and not yet accepted, and 0 otherwise.
- R11: When several pins are pending, messages are issued lowest pin number first, one per handshake.
- R12: While `msg_valid` is high and `msg_ready` is low, `msg_valid` and every message field stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the window selected by bus_addr |
| bus_addr | input | 5 | Window byte offset: 0x00 index, 0x10 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the window at bus_addr |
| irq_in | input | NUM_PINS | Interrupt input pins |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt pulse |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Destination mode, 1 = logical |
| msg_dest | output | 8 | Destination |

## Verification
The assertions assume the following about the inputs:
- the pins, bus strobes and end-of-interrupt inputs are synchronous to `clk`;
- `eoi_valid` is a single-cycle pulse;
- software does not rewrite an entry's delivery mode while that entry's message is waiting at the output.

The stimulus keeps within these limits. It changes every input on the falling edge and pulses end-of-interrupt for exactly one cycle. It reprograms or masks an entry only after its message has been accepted. It holds `msg_ready` low except for single-cycle acceptances, so that back-pressure is exercised on every message.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam logic [4:0] WIN_INDEX = 5'h00;
  localparam logic [4:0] WIN_DATA  = 5'h10;
  localparam logic [7:0] ENT_BASE  = 8'h10;

  // writable bits of an entry word
  localparam logic [31:0] LO_WMASK = 32'h0001_AFFF;

  typedef struct packed {
    logic       mask;
    logic       level;
    logic       act_low;
    logic       logical;
    logic [2:0] mode;
    logic [7:0] vector;
  } route_t;

  // delivery modes 3 and 6 are reserved and never issue a message
  function automatic logic mode_ok(input logic [2:0] m);
    return (m != 3'd3) && (m != 3'd6);
  endfunction
endpackage

// File: rtl/irc_pin_ctl.sv
module irc_pin_ctl #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic [NUM_PINS-1:0] act_low,
  input  logic [NUM_PINS-1:0] level,
  input  logic [NUM_PINS-1:0] enable,
  input  logic [NUM_PINS-1:0] accept,
  input  logic [NUM_PINS-1:0] eoi_hit,
  output logic [NUM_PINS-1:0] req,
  output logic [NUM_PINS-1:0] irr
);
  logic [NUM_PINS-1:0] active, active_q, pend;

  assign active = irq_in ^ act_low;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        active_q[i] <= 1'b0;
        pend[i]     <= 1'b0;
        irr[i]      <= 1'b0;
      end else begin
        active_q[i] <= active[i];
        if (active[i] && !active_q[i] && enable[i] && !level[i])
          pend[i] <= 1'b1;
        else if (accept[i] || level[i])
          pend[i] <= 1'b0;
        if (accept[i] && level[i])
          irr[i] <= 1'b1;
        else if (eoi_hit[i])
          irr[i] <= 1'b0;
      end
    end

    assign req[i] = enable[i] && (level[i] ? (active[i] && !irr[i]) : pend[i]);

    // R7: remote IRR only drops after a matching end-of-interrupt
    a_r7_irr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irr[i]) |-> $past(eoi_hit[i]));
  end
endmodule

// File: rtl/irc_arbiter.sv
module irc_arbiter #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic [NUM_PINS-1:0] req,
  output logic                grant_valid,
  output logic [PIN_W-1:0]    grant_pin
);
  always_comb begin
    grant_valid = 1'b0;
    grant_pin   = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant_valid = 1'b1;
        grant_pin   = PIN_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_route_ctl.sv
module irq_route_ctl
  import irc_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h20,
  parameter logic       CAP_FLAG = 1'b1,
  parameter logic       DT_FLAG  = 1'b0,
  parameter logic       LTS_FLAG = 1'b0,
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [4:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic                eoi_valid,
  input  logic [7:0]          eoi_vector,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_vector,
  output logic [2:0]          msg_mode,
  output logic                msg_logical,
  output logic [7:0]          msg_dest
);
  localparam logic [8:0] ENT_END = 9'(16 + 2 * NUM_PINS);

  logic [7:0] idx_q, unit_id;
  logic [3:0] arb_id;
  route_t     ent  [NUM_PINS];
  logic [7:0] dest [NUM_PINS];

  // index decode
  logic [7:0]       ent_off;
  logic             ent_hit;
  logic [PIN_W-1:0] ent_pin;
  logic             data_wr;

  assign ent_off = idx_q - ENT_BASE;
  assign ent_hit = (idx_q >= ENT_BASE) && ({1'b0, idx_q} < ENT_END);
  assign ent_pin = ent_off[PIN_W:1];
  assign data_wr = bus_wr && (bus_addr == WIN_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      unit_id <= '0;
      arb_id  <= '0;
    end else if (bus_wr && bus_addr == WIN_INDEX) begin
      idx_q <= bus_wdata[7:0];
    end else if (data_wr) begin
      if (idx_q == 8'h00) unit_id <= bus_wdata[31:24];
      if (idx_q == 8'h02) arb_id  <= bus_wdata[27:24];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_PINS; i++) begin
      if (!rst_n) begin
        ent[i]  <= '{mask: 1'b1, default: '0};
        dest[i] <= '0;
      end else if (data_wr && ent_hit && ent_pin == PIN_W'(i)) begin
        if (idx_q[0]) dest[i] <= bus_wdata[31:24];
        else ent[i] <= '{mask: bus_wdata[16], level: bus_wdata[15],
                         act_low: bus_wdata[13], logical: bus_wdata[11],
                         mode: bus_wdata[10:8], vector: bus_wdata[7:0]};
      end
    end
  end

  // per-pin control vectors
  logic [NUM_PINS-1:0] act_low_v, level_v, enable_v, accept_v, eoi_hit_v, req_v, irr_v;
  logic                out_valid;
  logic [PIN_W-1:0]    out_pin;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      act_low_v[i] = ent[i].act_low;
      level_v[i]   = ent[i].level;
      enable_v[i]  = !ent[i].mask && mode_ok(ent[i].mode);
      eoi_hit_v[i] = eoi_valid && ent[i].level && (ent[i].vector == eoi_vector);
      accept_v[i]  = out_valid && msg_ready && (out_pin == PIN_W'(i));
    end
  end

  irc_pin_ctl #(.NUM_PINS(NUM_PINS)) u_pins (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .act_low(act_low_v),
    .level(level_v), .enable(enable_v), .accept(accept_v),
    .eoi_hit(eoi_hit_v), .req(req_v), .irr(irr_v)
  );

  logic             grant_valid;
  logic [PIN_W-1:0] grant_pin;

  irc_arbiter #(.NUM_PINS(NUM_PINS)) u_arb (
    .req(req_v), .grant_valid(grant_valid), .grant_pin(grant_pin)
  );

  // output stage: load only when empty, hold until handshake
  route_t     win;
  logic [7:0] win_dest;
  assign win      = ent[grant_pin];
  assign win_dest = win.logical ? dest[grant_pin] : {4'b0, dest[grant_pin][3:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_pin     <= '0;
      msg_vector  <= '0;
      msg_mode    <= '0;
      msg_logical <= 1'b0;
      msg_dest    <= '0;
    end else if (!out_valid) begin
      if (grant_valid) begin
        out_valid   <= 1'b1;
        out_pin     <= grant_pin;
        msg_vector  <= win.vector;
        msg_mode    <= win.mode;
        msg_logical <= win.logical;
        msg_dest    <= win_dest;
      end
    end else if (msg_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign msg_valid = out_valid;

  // read path
  logic [31:0] reg_rd;
  always_comb begin
    reg_rd = '0;
    if (idx_q == 8'h00)      reg_rd = {unit_id, 8'h00, DT_FLAG, LTS_FLAG, 14'h0};
    else if (idx_q == 8'h01) reg_rd = {8'h00, 8'(NUM_PINS - 1), CAP_FLAG, 7'h00, VERSION};
    else if (idx_q == 8'h02) reg_rd = {4'h0, arb_id, 24'h0};
    else if (ent_hit) begin
      if (idx_q[0]) reg_rd = {dest[ent_pin], 24'h0};
      else reg_rd = {15'h0, ent[ent_pin].mask, ent[ent_pin].level, irr_v[ent_pin],
                     ent[ent_pin].act_low, req_v[ent_pin], ent[ent_pin].logical,
                     ent[ent_pin].mode, ent[ent_pin].vector};
    end
  end

  always_comb begin
    if (bus_addr == WIN_INDEX)     bus_rdata = {24'h0, idx_q};
    else if (bus_addr == WIN_DATA) bus_rdata = reg_rd;
    else                           bus_rdata = '0;
  end

  // R12: back-pressure holds the message unchanged
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_mode)
      && $stable(msg_logical) && $stable(msg_dest));

  // R8: reserved delivery modes never reach the output
  a_r8_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> mode_ok(msg_mode));

  // R9: physical destinations carry only four bits
  a_r9_phys_dest: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_logical |-> msg_dest[7:4] == 4'h0);

  // R11: at most one pin is accepted per handshake
  a_r11_one_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(accept_v));
endmodule

// File: tb/tb_irq_route_ctl.sv
`timescale 1ns/1ps
module tb_irq_route_ctl;
  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_in = '0;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;
  logic        msg_valid, msg_ready = 1'b0;
  logic [7:0]  msg_vector, msg_dest;
  logic [2:0]  msg_mode;
  logic        msg_logical;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  irq_route_ctl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_mode(msg_mode),
    .msg_logical(msg_logical), .msg_dest(msg_dest)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr_win(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [31:0] d);
    wr_win(5'h00, {24'h0, idx});
    wr_win(5'h10, d);
  endtask

  task automatic rd_reg(input logic [7:0] idx, output logic [31:0] d);
    wr_win(5'h00, {24'h0, idx});
    bus_addr = 5'h10; #1; d = bus_rdata;
  endtask

  // waits for a message, captures it, accepts it in one cycle
  task automatic take_msg(output logic got, output logic [7:0] v, output logic [2:0] m,
                          output logic l, output logic [7:0] ds);
    got = 1'b0; v = '0; m = '0; l = 1'b0; ds = '0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (msg_valid) begin got = 1'b1; break; end
    end
    if (got) begin
      v = msg_vector; m = msg_mode; l = msg_logical; ds = msg_dest;
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
    end
  endtask

  task automatic quiet(input int cyc, input string tag);
    logic seen = 1'b0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    check(!seen, tag, {31'h0, seen}, 32'h0);
  endtask

  function automatic logic [2:0] mode_of(input int p);
    case (p % 6)
      0: return 3'd0; 1: return 3'd1; 2: return 3'd2;
      3: return 3'd4; 4: return 3'd5; default: return 3'd7;
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog all requirements act=hung exp=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic got, lg;
    logic [7:0] v, ds, edest;
    logic [2:0] m;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd_reg(8'h00, d); check(d == 32'h0, "R2 reset id", d, 32'h0);
    rd_reg(8'h01, d); check(d == 32'h0017_8020, "R3 version reg", d, 32'h0017_8020);
    rd_reg(8'h02, d); check(d == 32'h0, "R4 reset arb", d, 32'h0);
    rd_reg(8'h10, d); check(d == 32'h0001_0000, "R5 reset low", d, 32'h0001_0000);
    rd_reg(8'h11, d); check(d == 32'h0, "R5 reset high", d, 32'h0);
    check(!msg_valid, "R12 reset valid", {31'h0, msg_valid}, 32'h0);

    // register access
    wr_reg(8'h00, 32'hFFFF_FFFF); rd_reg(8'h00, d);
    check(d == 32'hFF00_0000, "R2 id write", d, 32'hFF00_0000);
    wr_reg(8'h01, 32'hFFFF_FFFF); rd_reg(8'h01, d);
    check(d == 32'h0017_8020, "R3 write ignored", d, 32'h0017_8020);
    wr_reg(8'h02, 32'hFFFF_FFFF); rd_reg(8'h02, d);
    check(d == 32'h0F00_0000, "R4 arb write", d, 32'h0F00_0000);
    wr_win(5'h00, 32'h23); bus_addr = 5'h00; #1;
    check(bus_rdata == 32'h23, "R1 index readback", bus_rdata, 32'h23);
    wr_reg(8'h17, 32'h1234_5678); bus_addr = 5'h10; #1;
    check(bus_rdata == 32'h1200_0000, "R1 data write", bus_rdata, 32'h1200_0000);
    wr_win(5'h10, 32'hABFF_FFFF); bus_addr = 5'h10; #1;
    check(bus_rdata == 32'hAB00_0000, "R1 repeated data write", bus_rdata, 32'hAB00_0000);
    wr_reg(8'h16, 32'hFFFF_FFFF); rd_reg(8'h16, d);
    check(d == 32'h0001_AFFF, "R5 low writable bits", d, 32'h0001_AFFF);
    wr_reg(8'h16, 32'h0001_0000);
    rd_reg(8'h05, d); check(d == 32'h0, "R5 unimplemented 0x05", d, 32'h0);
    wr_reg(8'h40, 32'hFFFF_FFFF); rd_reg(8'h40, d);
    check(d == 32'h0, "R5 unimplemented 0x40", d, 32'h0);

    // R6/R9 sweep: every pin, edge triggered
    for (int p = 0; p < N; p++) begin
      wr_reg(8'(16 + 2 * p + 1), {8'(8'hA0 + p), 24'h0});
      wr_reg(8'(16 + 2 * p), {21'h0, logic'(p & 1), mode_of(p), 8'(8'h30 + p)});
      @(negedge clk); irq_in[p] = 1'b1;
      take_msg(got, v, m, lg, ds);
      edest = (p & 1) ? 8'(8'hA0 + p) : {4'h0, 4'(p)};
      check(got && v == 8'(8'h30 + p) && m == mode_of(p) && lg == logic'(p & 1) && ds == edest,
            "R9 message fields", {got, 4'h0, m, lg, 7'h0, v, ds}, {1'b1, 4'h0, mode_of(p), logic'(p & 1), 7'h0, 8'(8'h30 + p), edest});
      quiet(8, "R6 single message while held");
      irq_in[p] = 1'b0;
      quiet(4, "R6 no message on release");
      wr_reg(8'(16 + 2 * p), 32'h0001_0000);
    end

    // active-low edge pin
    irq_in[5] = 1'b1;
    wr_reg(8'h1B, 32'h0A00_0000);
    wr_reg(8'h1A, 32'h0000_2055);
    quiet(4, "R6 active low idle");
    @(negedge clk); irq_in[5] = 1'b0;
    take_msg(got, v, m, lg, ds);
    check(got && v == 8'h55 && ds == 8'h0A, "R6 active low fires", {got, 15'h0, v, ds}, {1'b1, 15'h0, 8'h55, 8'h0A});
    irq_in[5] = 1'b1;
    quiet(6, "R6 active low release");
    wr_reg(8'h1A, 32'h0001_0000);
    irq_in[5] = 1'b0;

    // masked and reserved modes
    wr_reg(8'h14, 32'h0001_0022);
    @(negedge clk); irq_in[2] = 1'b1;
    quiet(8, "R8 masked pin");
    rd_reg(8'h14, d); check(d == 32'h0001_0022, "R8 masked status", d, 32'h0001_0022);
    irq_in[2] = 1'b0;
    wr_reg(8'h18, 32'h0000_0344);
    @(negedge clk); irq_in[4] = 1'b1;
    quiet(8, "R8 reserved mode 3");
    irq_in[4] = 1'b0;
    wr_reg(8'h18, 32'h0000_0644);
    @(negedge clk); irq_in[4] = 1'b1;
    quiet(8, "R8 reserved mode 6");
    irq_in[4] = 1'b0;
    wr_reg(8'h18, 32'h0001_0000);

    // level pin with back-pressure and end-of-interrupt
    wr_reg(8'h1F, 32'h0000_0000);
    wr_reg(8'h1E, 32'h0000_8077);
    @(negedge clk); irq_in[7] = 1'b1;
    repeat (3) @(negedge clk);
    check(msg_valid && msg_vector == 8'h77, "R7 level fires", {23'h0, msg_valid, msg_vector}, {23'h0, 1'b1, 8'h77});
    rd_reg(8'h1E, d); check(d == 32'h0000_9077, "R10 status while pending", d, 32'h0000_9077);
    begin
      logic held = 1'b1;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        if (!msg_valid || msg_vector != 8'h77) held = 1'b0;
      end
      check(held, "R12 hold under back-pressure", {31'h0, held}, 32'h1);
    end
    take_msg(got, v, m, lg, ds);
    rd_reg(8'h1E, d); check(d == 32'h0000_C077, "R7 remote IRR set", d, 32'h0000_C077);
    quiet(8, "R7 quiet while IRR set");
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = 8'h55;
    @(negedge clk); eoi_valid = 1'b0;
    quiet(6, "R7 other vector ignored");
    rd_reg(8'h1E, d); check(d == 32'h0000_C077, "R7 IRR kept", d, 32'h0000_C077);
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = 8'h77;
    @(negedge clk); eoi_valid = 1'b0;
    take_msg(got, v, m, lg, ds);
    check(got && v == 8'h77, "R7 refire after EOI", {23'h0, got, v}, {23'h0, 1'b1, 8'h77});
    irq_in[7] = 1'b0;
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = 8'h77;
    @(negedge clk); eoi_valid = 1'b0;
    quiet(6, "R7 no refire when inactive");
    rd_reg(8'h1E, d); check(d == 32'h0000_8077, "R10 status idle", d, 32'h0000_8077);
    wr_reg(8'h1E, 32'h0001_0000);

    // priority order
    wr_reg(8'h16, 32'h0000_0093);
    wr_reg(8'h22, 32'h0000_0099);
    wr_reg(8'h38, 32'h0000_00A4);
    @(negedge clk); irq_in[3] = 1'b1; irq_in[9] = 1'b1; irq_in[20] = 1'b1;
    take_msg(got, v, m, lg, ds); check(got && v == 8'h93, "R11 first lowest pin", {23'h0, got, v}, {23'h0, 1'b1, 8'h93});
    take_msg(got, v, m, lg, ds); check(got && v == 8'h99, "R11 second pin", {23'h0, got, v}, {23'h0, 1'b1, 8'h99});
    take_msg(got, v, m, lg, ds); check(got && v == 8'hA4, "R11 third pin", {23'h0, got, v}, {23'h0, 1'b1, 8'hA4});
    quiet(6, "R11 no extra message");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule